// File: doc/BRIEF.md
# Scan-Driven Connection Status Capture Buffer

This block sits beside a connection scanner. The scanner walks the connection records held in external memory and hands each record to the block as one wide beat. While a pass is running and capture is switched on, the block takes one 32-bit word out of every record and pushes it into a 32-entry first-in first-out store. The word taken is either the raw record word that a programmable index points at, or a packed word. The packed word is built from the low flag field of every word in the record. In the same handshake cycle the block can return a rewritten copy of the indexed word to the memory side. The rewrite is driven by a programmable mask and value, and is typically used to clear transition flags once they have been reported.

A request line tells the processor that captured data is waiting. The line rises when the store becomes full, or when a pass ends with at least one entry stored. While the line is high, the scanner is held off at the record handshake, so no captured word is dropped. The processor drains the store through a first-word-fall-through read port. The request falls once the last entry has been read, and the scan then resumes.

Top module: `dmabuf_scan_top`

## Requirements
- R1: After synchronous reset, dma_req is low, the store is empty and rec_ready is high.
- R2: When cfg_dma_en is low or pass_active is low, every record is accepted (rec_ready high). Nothing is stored and wb_valid stays low.
- R3: In raw mode (cfg_packed low), the stored word is record word cfg_word_sel. Word k occupies rec_data bits [32k+31:32k].
- R4: In packed mode (cfg_packed high), bits [4k+3:4k] of the stored word are bits [3:0] of record word k, for k = 0 to 7.
- R5: In a capture cycle with cfg_ovr_mask non-zero, wb_valid is high, wb_idx equals cfg_word_sel, and wb_data equals (raw indexed word & ~mask) | (value & mask). With a zero mask, wb_valid stays low.
- R6: The store holds 32 entries. dma_req rises at the clock edge that stores the 32nd entry.
- R7: dma_req rises at the first clock edge that samples pass_active low after it was high, if the store is non-empty at that point. If the store is empty, dma_req stays low.
- R8: While dma_req is high and capture is enabled, rec_ready is low. No record is captured until the store has been drained.
- R9: While dma_req is high, rd_data shows the oldest entry and rd_en removes it. Entries come out in capture order.
- R10: While dma_req is low, rd_en has no effect. The entry on rd_data and the stored count are unchanged.
- R11: dma_req falls at the edge that removes the last entry. It stays low even if the pass ends in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dma_en | input | 1 | Capture enable |
| cfg_packed | input | 1 | 1 selects the packed flag word |
| cfg_word_sel | input | 3 | Index of the record word to capture and rewrite |
| cfg_ovr_mask | input | 32 | Bits to overwrite in the indexed word |
| cfg_ovr_value | input | 32 | Replacement values for the masked bits |
| pass_active | input | 1 | High while a scan pass runs |
| rec_valid | input | 1 | Record beat valid |
| rec_data | input | 256 | Full connection record, word 0 in the low bits |
| rec_ready | output | 1 | Record accepted (low = scanner stalled) |
| wb_valid | output | 1 | Rewrite of the indexed word to memory |
| wb_idx | output | 3 | Word index of the rewrite |
| wb_data | output | 32 | Rewritten word |
| dma_req | output | 1 | Captured data waiting for the processor |
| rd_en | input | 1 | Processor read strobe |
| rd_data | output | 32 | Oldest stored entry |

## Verification
Two events can meet in one cycle: the processor removes the final entry, and the scanner drops pass_active. The fall must win, and no fresh request may be raised, because the store is then empty. A directed case fills the store mid-pass, drains all but one entry under the stall, and then presents the final read together with the pass end. The bench compares dma_req on the next cycle, and the restored rec_ready, against its reference queue. Random runs with their own pass toggles and read strobes revisit the same meeting, and also a 32nd capture followed at once by a pass end.

// File: rtl/dmabuf_pkg.sv
package dmabuf_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_RAW    = 1'b0,
        MODE_PACKED = 1'b1
    } cap_mode_t;

    typedef enum logic {
        REQ_IDLE  = 1'b0,
        REQ_DRAIN = 1'b1
    } req_state_t;

    typedef struct packed {
        logic push;
        logic pop;
    } fifo_op_t;

    function automatic word_t merge_bits(word_t old_w, word_t mask, word_t val);
        return (old_w & ~mask) | (val & mask);
    endfunction

endpackage

// File: rtl/dmabuf_select.sv
module dmabuf_select
    import dmabuf_pkg::*;
#(
    parameter int WORDS = 8,
    localparam int IDX_W = $clog2(WORDS),
    localparam int REC_W = WORDS * WORD_W
) (
    input  logic [REC_W-1:0] rec_data,
    input  logic [IDX_W-1:0] word_sel,
    input  cap_mode_t        mode,
    input  word_t            ovr_mask,
    input  word_t            ovr_value,
    output word_t            cap_word,
    output word_t            wb_word
);
    localparam int FW = WORD_W / WORDS;

    word_t words [WORDS];
    word_t packed_w;
    word_t raw_w;

    for (genvar k = 0; k < WORDS; k++) begin : g_split
        assign words[k] = rec_data[k*WORD_W +: WORD_W];
        assign packed_w[k*FW +: FW] = words[k][FW-1:0];
    end

    if (FW * WORDS < WORD_W) begin : g_pad
        assign packed_w[WORD_W-1:FW*WORDS] = '0;
    end

    always_comb begin
        raw_w    = words[word_sel];
        cap_word = (mode == MODE_PACKED) ? packed_w : raw_w;
        wb_word  = merge_bits(raw_w, ovr_mask, ovr_value);
    end

endmodule

// File: rtl/dmabuf_fifo.sv
module dmabuf_fifo
    import dmabuf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_op_t      op,
    input  word_t         din,
    output word_t         dout,
    output logic [CW-1:0] level_next,
    output logic          full,
    output logic          empty
);
    word_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] level;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        level_next = level + CW'(op.push) - CW'(op.pop);
        full       = (level == CW'(DEPTH));
        empty      = (level == '0);
        dout       = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (op.push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (op.push) wr_ptr <= bump(wr_ptr);
            if (op.pop)  rd_ptr <= bump(rd_ptr);
            level <= level_next;
        end
    end

endmodule

// File: rtl/dmabuf_req.sv
module dmabuf_req
    import dmabuf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pass_active,
    input  logic [CW-1:0] level_next,
    output logic          req
);
    req_state_t state_q;
    req_state_t state_d;
    logic       pass_q;
    logic       pass_end;
    logic       hit_full;
    logic       has_data;

    always_comb begin
        pass_end = pass_q & ~pass_active;
        hit_full = (level_next == CW'(DEPTH));
        has_data = (level_next != '0);
        state_d  = state_q;
        unique case (state_q)
            REQ_IDLE:  if (hit_full || (pass_end && has_data)) state_d = REQ_DRAIN;
            REQ_DRAIN: if (!has_data) state_d = REQ_IDLE;
            default:   state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= REQ_IDLE;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pass_q  <= pass_active;
        end
    end

    assign req = (state_q == REQ_DRAIN);

endmodule

// File: rtl/dmabuf_scan_top.sv
module dmabuf_scan_top
    import dmabuf_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(WORDS),
    localparam int REC_W = WORDS * WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_dma_en,
    input  logic             cfg_packed,
    input  logic [IDX_W-1:0] cfg_word_sel,
    input  logic [31:0]      cfg_ovr_mask,
    input  logic [31:0]      cfg_ovr_value,
    input  logic             pass_active,
    input  logic             rec_valid,
    input  logic [REC_W-1:0] rec_data,
    output logic             rec_ready,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_idx,
    output logic [31:0]      wb_data,
    output logic             dma_req,
    input  logic             rd_en,
    output logic [31:0]      rd_data
);
    localparam int CW = $clog2(DEPTH) + 1;

    cap_mode_t     mode;
    word_t         cap_word;
    word_t         wb_word;
    fifo_op_t      op;
    logic [CW-1:0] level_next;
    logic          full;
    logic          empty;
    logic          capture_on;
    logic          req;

    assign mode = cfg_packed ? MODE_PACKED : MODE_RAW;

    dmabuf_select #(.WORDS(WORDS)) u_select (
        .rec_data  (rec_data),
        .word_sel  (cfg_word_sel),
        .mode      (mode),
        .ovr_mask  (cfg_ovr_mask),
        .ovr_value (cfg_ovr_value),
        .cap_word  (cap_word),
        .wb_word   (wb_word)
    );

    always_comb begin
        capture_on = cfg_dma_en & pass_active;
        rec_ready  = ~capture_on | (~req & ~full);
        op.push    = rec_valid & capture_on & ~req & ~full;
        op.pop     = rd_en & req & ~empty;
        wb_valid   = op.push & (cfg_ovr_mask != '0);
        wb_idx     = cfg_word_sel;
        wb_data    = wb_word;
    end

    dmabuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .din        (cap_word),
        .dout       (rd_data),
        .level_next (level_next),
        .full       (full),
        .empty      (empty)
    );

    dmabuf_req #(.DEPTH(DEPTH)) u_req (
        .clk         (clk),
        .rst         (rst),
        .pass_active (pass_active),
        .level_next  (level_next),
        .req         (req)
    );

    assign dma_req = req;

endmodule

// File: rtl/dmabuf_scan_checker.sv
module dmabuf_scan_checker #(
    parameter int WORDS = 8,
    localparam int IDX_W = $clog2(WORDS),
    localparam int REC_W = WORDS * 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_dma_en,
    input logic             cfg_packed,
    input logic [IDX_W-1:0] cfg_word_sel,
    input logic [31:0]      cfg_ovr_mask,
    input logic [31:0]      cfg_ovr_value,
    input logic             pass_active,
    input logic             rec_valid,
    input logic [REC_W-1:0] rec_data,
    input logic             rec_ready,
    input logic             wb_valid,
    input logic [IDX_W-1:0] wb_idx,
    input logic [31:0]      wb_data,
    input logic             dma_req,
    input logic             rd_en,
    input logic [31:0]      rd_data
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dma_req && rec_ready));

    assert_no_capture_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !(cfg_dma_en && pass_active) |-> (rec_ready && !wb_valid));

    assert_wb_masked_bits_R5: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (((wb_data ^ cfg_ovr_value) & cfg_ovr_mask) == 32'd0 && wb_idx == cfg_word_sel));

    assert_no_wb_zero_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_ovr_mask == 32'd0) |-> !wb_valid);

    assert_stall_while_req_R8: assert property (@(posedge clk) disable iff (rst)
        (dma_req && pass_active && cfg_dma_en) |-> !rec_ready);

    assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !rd_en) |=> dma_req);

endmodule

bind dmabuf_scan_top dmabuf_scan_checker #(.WORDS(WORDS)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_dma_en    (cfg_dma_en),
    .cfg_packed    (cfg_packed),
    .cfg_word_sel  (cfg_word_sel),
    .cfg_ovr_mask  (cfg_ovr_mask),
    .cfg_ovr_value (cfg_ovr_value),
    .pass_active   (pass_active),
    .rec_valid     (rec_valid),
    .rec_data      (rec_data),
    .rec_ready     (rec_ready),
    .wb_valid      (wb_valid),
    .wb_idx        (wb_idx),
    .wb_data       (wb_data),
    .dma_req       (dma_req),
    .rd_en         (rd_en),
    .rd_data       (rd_data)
);

// File: tb/test_dmabuf_scan_top.sv
`timescale 1ns/1ps
module test_dmabuf_scan_top;
    localparam int WORDS = 8;
    localparam int DEPTH = 32;
    localparam int IDX_W = 3;
    localparam int RW    = WORDS * 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_dma_en = 1'b0;
    logic             cfg_packed = 1'b0;
    logic [IDX_W-1:0] cfg_word_sel = '0;
    logic [31:0]      cfg_ovr_mask = '0;
    logic [31:0]      cfg_ovr_value = '0;
    logic             pass_active = 1'b0;
    logic             rec_valid = 1'b0;
    logic [RW-1:0]    rec_data = '0;
    logic             rec_ready;
    logic             wb_valid;
    logic [IDX_W-1:0] wb_idx;
    logic [31:0]      wb_data;
    logic             dma_req;
    logic             rd_en = 1'b0;
    logic [31:0]      rd_data;

    dmabuf_scan_top i_dmabuf_scan_top (.*);

    always #2.5 clk = ~clk;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    logic [31:0] q[$];
    bit          req_m;
    bit          passq_m;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] raw_word(logic [RW-1:0] r, logic [IDX_W-1:0] s);
        return r[s*32 +: 32];
    endfunction

    function automatic logic [31:0] exp_cap(logic [RW-1:0] r, logic [IDX_W-1:0] s, bit pk);
        logic [31:0] w;
        if (!pk) return raw_word(r, s);
        for (int k = 0; k < WORDS; k++) w[k*4 +: 4] = r[k*32 +: 4];
        return w;
    endfunction

    function automatic logic [RW-1:0] rand_rec();
        logic [RW-1:0] r;
        for (int k = 0; k < WORDS; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic step();
        bit on, exp_ready, fire, pop, pend;
        #1;
        on        = cfg_dma_en && pass_active;
        exp_ready = !on || (!req_m && q.size() < DEPTH);
        chk(rec_ready == exp_ready, exp_ready ? "R2 ready" : "R8 stall", 32'(rec_ready), 32'(exp_ready));
        chk(dma_req == req_m, "R6/R7/R11 dma_req", 32'(dma_req), 32'(req_m));
        fire = rec_valid && on && exp_ready;
        chk(wb_valid == (fire && cfg_ovr_mask != 0), "R5 wb_valid", 32'(wb_valid), 32'(fire && cfg_ovr_mask != 0));
        if (fire && cfg_ovr_mask != 0) begin
            chk(wb_idx == cfg_word_sel, "R5 wb_idx", 32'(wb_idx), 32'(cfg_word_sel));
            chk(wb_data == ((raw_word(rec_data, cfg_word_sel) & ~cfg_ovr_mask) | (cfg_ovr_value & cfg_ovr_mask)),
                "R5 wb_data", wb_data,
                (raw_word(rec_data, cfg_word_sel) & ~cfg_ovr_mask) | (cfg_ovr_value & cfg_ovr_mask));
        end
        if (q.size() > 0)
            chk(rd_data == q[0], cfg_packed ? "R4/R9/R10 rd_data" : "R3/R9/R10 rd_data", rd_data, q[0]);
        pop = rd_en && req_m && q.size() > 0;
        if (fire) q.push_back(exp_cap(rec_data, cfg_word_sel, cfg_packed));
        if (pop) void'(q.pop_front());
        pend    = passq_m && !pass_active;
        req_m   = (req_m && q.size() != 0) || (q.size() == DEPTH) || (pend && q.size() != 0);
        passq_m = pass_active;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cyc(bit v, bit rd);
        rec_valid = v;
        rd_en     = rd;
        rec_data  = rand_rec();
        step();
    endtask

    task automatic drain();
        while (q.size() > 0) cyc(1'b1, 1'b1);
        cyc(1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        q.delete();
        req_m = 0;
        passq_m = 0;
        #1;
        chk(dma_req == 1'b0, "R1 reset req", 32'(dma_req), 32'd0);
        chk(rec_ready == 1'b1, "R1 reset ready", 32'(rec_ready), 32'd1);
        @(negedge clk);

        // R2: pass with capture disabled stores nothing
        pass_active = 1'b1;
        cfg_ovr_mask = 32'hFFFF_0000;
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0);
        pass_active = 1'b0;
        cyc(1'b0, 1'b0);
        chk(dma_req == 1'b0, "R2 no req after disabled pass", 32'(dma_req), 32'd0);

        // R3/R10: raw capture, reads ignored while no request
        cfg_dma_en = 1'b1;
        cfg_word_sel = 3'd5;
        cfg_ovr_mask = 32'd0;
        pass_active = 1'b1;
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1);
        pass_active = 1'b0;
        cyc(1'b0, 1'b1);
        chk(q.size() == 6, "R10 model count", 32'(q.size()), 32'd6);
        drain();

        // R7: pass end with empty store
        pass_active = 1'b1;
        cyc(1'b0, 1'b0);
        pass_active = 1'b0;
        cyc(1'b0, 1'b0);
        chk(dma_req == 1'b0, "R7 empty pass end", 32'(dma_req), 32'd0);

        // R4/R5/R6/R8/R11: packed, masked, fill, stall, last read meets pass end
        cfg_packed = 1'b1;
        cfg_word_sel = 3'd2;
        cfg_ovr_mask = 32'h0000_00F0;
        cfg_ovr_value = 32'h0000_0050;
        pass_active = 1'b1;
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0);
        chk(dma_req == 1'b1, "R6 full req", 32'(dma_req), 32'd1);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0);
        for (int i = 0; i < DEPTH - 1; i++) cyc(1'b1, 1'b1);
        pass_active = 1'b0;
        cyc(1'b0, 1'b1);
        chk(dma_req == 1'b0, "R11 last read with pass end", 32'(dma_req), 32'd0);

        // R6/R7: 32nd capture right before pass end
        cfg_packed = 1'b0;
        pass_active = 1'b1;
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0);
        pass_active = 1'b0;
        cyc(1'b0, 1'b0);
        chk(dma_req == 1'b1, "R6 req holds after pass end", 32'(dma_req), 32'd1);
        drain();

        // random mix
        for (int i = 0; i < 5000; i++) begin
            if ($urandom_range(99) < 3) pass_active = !pass_active;
            if (!pass_active && $urandom_range(99) < 5) begin
                cfg_dma_en    = ($urandom_range(9) != 0);
                cfg_packed    = $urandom_range(1);
                cfg_word_sel  = IDX_W'($urandom);
                cfg_ovr_mask  = ($urandom_range(3) == 0) ? 32'd0 : $urandom;
                cfg_ovr_value = $urandom;
            end
            cyc($urandom_range(99) < 70, $urandom_range(99) < 40);
        end
        pass_active = 1'b0;
        cyc(1'b0, 1'b0);
        drain();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule